// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is the control logic of a byte-wide memory whose volatile RAM array is mirrored by a nonvolatile shadow array. Four active-low strobes (chip select, output enable, write enable and a shadow-select strobe) are decoded into four operations. The first two are ordinary RAM reads and writes. The other two are whole-array transfers: a recall copies the shadow array into RAM, and a store copies RAM into the shadow array. A transfer runs for a fixed, parameterised number of clock cycles, which stands in for the real programming time. A busy output is high for the whole transfer.

A digital supply-good input replaces analog supply sensing. While it is low, the block does nothing. When it rises, the block starts a recall on its own. Several rules guard the shadow array. A store is refused unless RAM has been written since the last store or power-up. A transfer command must be held for a minimum number of clock edges before it counts. A command that is already present while the block is busy or unpowered is ignored until its strobes are released.

The data bus is modelled as a separate input and output, plus an output-enable signal for the external tristate driver. Both arrays are plain register arrays.

Top module: `snv_ctrl`

## Requirements
- R1: `dout_en` is 1 only when `cs_n`=0, `oe_n`=0, `we_n`=1, `nv_n`=1, `supply_ok`=1 and `busy`=0. In that case `dout` shows the RAM word at `addr`. In particular, `dout_en` is 0 whenever `oe_n`=1, `cs_n`=1 or `nv_n`=0.
- R2: At any rising edge where `cs_n`=0, `we_n`=0, `nv_n`=1, `supply_ok`=1 and `busy`=0, `din` is written into the RAM word at `addr`. The number of writes is unlimited.
- R3: The recall pattern is `cs_n`=0, `oe_n`=0, `we_n`=1, `nv_n`=0. If it is held for MIN_PULSE consecutive rising edges, a recall starts. `busy` is then 1 for exactly RECALL_CYCLES cycles, after which every RAM word equals the matching shadow word.
- R4: The store pattern is `cs_n`=0, `we_n`=0, `nv_n`=0, `oe_n`=1. If it is held for MIN_PULSE consecutive edges while the written flag is set, a store starts. `busy` is then 1 for exactly STORE_CYCLES cycles, after which the shadow array equals RAM and the written flag is cleared.
- R5: A store command given when no RAM write has occurred since the last completed store or the last power-up leaves `busy` at 0 and does not change the shadow array.
- R6: A recall or store pattern held for fewer than MIN_PULSE edges starts no transfer and changes no array.
- R7: A rising `supply_ok` starts a recall on the next edge, whatever the strobes show. It also clears the written flag, and it takes priority over a store pattern present at the same time.
- R8: While `supply_ok` is 0, `dout_en` is 0, no write happens and no transfer starts. If `supply_ok` drops during a transfer, `busy` falls on the next edge and the interrupted transfer leaves the shadow array unchanged.
- R9: While `busy` is 1, reads and writes have no effect. A command pattern that appears during `busy` or while power is off starts nothing until it has been released.
- R10: One continuous assertion of a command pattern starts at most one transfer, however long it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears both arrays |
| supply_ok | input | 1 | Supply-good indication |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Shadow-array select, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data (zero when not driving) |
| dout_en | output | 1 | Drive enable for the external tristate bus |
| busy | output | 1 | Store or recall in progress |

## Verification
Two things can land on the same clock edge: a rising `supply_ok` and a store command held on the strobes. To provoke this, the bench holds the store pattern while supply is low and keeps holding it through the rising edge and well past the power-up recall. The result is judged at the ports. `busy` must stay high for exactly the recall length, never the store length, and no second transfer may follow. A store command issued afterwards must be refused, which shows the written flag was cleared. A full read-back must then show the shadow contents, untouched by the interrupted store. A second overlap is also covered: the end of a transfer coinciding with a command that was held through it. There, `busy` must stay low after the transfer completes.

// File: rtl/snv_pkg.sv
package snv_pkg;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_RECALL = 2'd1,
        XF_STORE  = 2'd2
    } xfer_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic nv_n;
    } strobes_t;

    localparam int CMD_RECALL = 0;
    localparam int CMD_STORE  = 1;
    localparam int N_CMD      = 2;

endpackage

// File: rtl/snv_strobe_dec.sv
module snv_strobe_dec
    import snv_pkg::*;
(
    input  strobes_t               stb,
    input  logic                   supply_ok,
    input  logic                   busy,
    output logic                   allow,
    output logic                   rd_act,
    output logic                   wr_act,
    output logic [N_CMD-1:0]       cmd_lvl
);

    always_comb begin
        allow   = supply_ok & ~busy;
        // plain RAM access, shadow strobe inactive
        rd_act  = allow & ~stb.cs_n & ~stb.oe_n & stb.we_n & stb.nv_n;
        wr_act  = allow & ~stb.cs_n & ~stb.we_n & stb.nv_n;
        // raw transfer levels, qualified later by width filters
        cmd_lvl = '0;
        cmd_lvl[CMD_RECALL] = ~stb.cs_n & ~stb.oe_n &  stb.we_n & ~stb.nv_n;
        cmd_lvl[CMD_STORE]  = ~stb.cs_n &  stb.oe_n & ~stb.we_n & ~stb.nv_n;
    end

endmodule

// File: rtl/snv_pulse_filter.sv
module snv_pulse_filter #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic level,
    output logic fire
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold;   // wait for release before counting again
    } flt_t;

    flt_t q, d;

    always_comb begin
        d    = q;
        fire = 1'b0;
        if (!level) begin
            d.cnt  = '0;
            d.hold = 1'b0;
        end else if (!allow || q.hold) begin
            d.cnt  = '0;
            d.hold = 1'b1;
        end else if (q.cnt == LAST) begin
            fire   = 1'b1;
            d.cnt  = '0;
            d.hold = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/snv_xfer_seq.sv
module snv_xfer_seq
    import snv_pkg::*;
#(
    parameter int RECALL_CYCLES = 250,
    parameter int STORE_CYCLES  = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic recall_req,
    input  logic store_req,
    input  logic wr_act,
    output logic busy,
    output logic recall_done,
    output logic store_done
);

    localparam int MAXC  = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] R_LOAD = CNT_W'(RECALL_CYCLES - 1);
    localparam logic [CNT_W-1:0] S_LOAD = CNT_W'(STORE_CYCLES - 1);

    typedef struct packed {
        xfer_e            mode;
        logic [CNT_W-1:0] cnt;
        logic             sup;      // supply_ok seen at previous edge
        logic             written;  // RAM written since last store/power-up
    } seq_t;

    seq_t q, d;

    always_comb begin
        d           = q;
        recall_done = 1'b0;
        store_done  = 1'b0;
        d.sup       = supply_ok;
        if (wr_act) d.written = 1'b1;

        if (!supply_ok) begin
            // everything inhibited; a running transfer is abandoned
            d.mode = XF_IDLE;
            d.cnt  = '0;
        end else if (!q.sup) begin
            // power-up recall has top priority
            d.mode    = XF_RECALL;
            d.cnt     = R_LOAD;
            d.written = 1'b0;
        end else if (q.mode != XF_IDLE) begin
            if (q.cnt == '0) begin
                if (q.mode == XF_STORE) begin
                    store_done = 1'b1;
                    d.written  = 1'b0;
                end else begin
                    recall_done = 1'b1;
                end
                d.mode = XF_IDLE;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else if (recall_req) begin
            d.mode = XF_RECALL;
            d.cnt  = R_LOAD;
        end else if (store_req && q.written) begin
            d.mode = XF_STORE;
            d.cnt  = S_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: XF_IDLE, cnt: '0, sup: 1'b0, written: 1'b0};
        else        q <= d;
    end

    assign busy = (q.mode != XF_IDLE);

endmodule

// File: rtl/snv_arrays.sv
module snv_arrays #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              recall_done,
    input  logic              store_done,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef logic [DEPTH-1:0][DATA_W-1:0] arr_t;

    typedef struct packed {
        arr_t ram;
        arr_t nv;
    } mem_t;

    mem_t q, d;

    always_comb begin
        d = q;
        if (recall_done)     d.ram = q.nv;
        else if (store_done) d.nv  = q.ram;
        if (wr_en)           d.ram[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.ram[addr];

endmodule

// File: rtl/snv_ctrl.sv
module snv_ctrl
    import snv_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 4,
    parameter int RECALL_CYCLES = 250,
    parameter int STORE_CYCLES  = 250000,
    parameter int MIN_PULSE     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              nv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);

    strobes_t          stb;
    logic              allow;
    logic              rd_act;
    logic              wr_act;
    logic [N_CMD-1:0]  cmd_lvl;
    logic [N_CMD-1:0]  cmd_fire;
    logic              recall_done;
    logic              store_done;
    logic [DATA_W-1:0] rdata;

    assign stb = '{cs_n: cs_n, oe_n: oe_n, we_n: we_n, nv_n: nv_n};

    snv_strobe_dec u_dec (
        .stb       (stb),
        .supply_ok (supply_ok),
        .busy      (busy),
        .allow     (allow),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .cmd_lvl   (cmd_lvl)
    );

    for (genvar g = 0; g < N_CMD; g++) begin : g_flt
        snv_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .allow (allow),
            .level (cmd_lvl[g]),
            .fire  (cmd_fire[g])
        );
    end

    snv_xfer_seq #(
        .RECALL_CYCLES (RECALL_CYCLES),
        .STORE_CYCLES  (STORE_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .recall_req  (cmd_fire[CMD_RECALL]),
        .store_req   (cmd_fire[CMD_STORE]),
        .wr_act      (wr_act),
        .busy        (busy),
        .recall_done (recall_done),
        .store_done  (store_done)
    );

    snv_arrays #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_act),
        .addr        (addr),
        .wdata       (din),
        .recall_done (recall_done),
        .store_done  (store_done),
        .rdata       (rdata)
    );

    assign dout_en = rd_act;
    assign dout    = rd_act ? rdata : '0;

endmodule

// File: rtl/snv_ctrl_chk.sv
module snv_ctrl_chk #(
    parameter int RECALL_CYCLES = 250,
    parameter int STORE_CYCLES  = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic cs_n,
    input logic oe_n,
    input logic nv_n,
    input logic dout_en,
    input logic busy,
    input logic wr_act
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    a_r1_bus_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || cs_n || !nv_n) |-> !dout_en);

    a_r8_supply_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!busy && !dout_en));

    a_r7_powerup_recall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |=> busy);

    a_r9_busy_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!dout_en && !wr_act));

    // R3 and R4: a completed transfer lasts exactly one of the two lengths
    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(supply_ok)) |->
            (run_q == RECALL_CYCLES || run_q == STORE_CYCLES));

endmodule

bind snv_ctrl snv_ctrl_chk #(
    .RECALL_CYCLES (RECALL_CYCLES),
    .STORE_CYCLES  (STORE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .nv_n      (nv_n),
    .dout_en   (dout_en),
    .busy      (busy),
    .wr_act    (wr_act)
);

// File: tb/sim_snv_ctrl.sv
module sim_snv_ctrl;

    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int RC    = 6;
    localparam int SC    = 20;
    localparam int MP    = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] ram_m [DEPTH];
    logic [DW-1:0] nv_m  [DEPTH];

    always #10 clk = ~clk;

    snv_ctrl #(
        .DATA_W(DW), .ADDR_W(AW), .RECALL_CYCLES(RC),
        .STORE_CYCLES(SC), .MIN_PULSE(MP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; nv_n = 1'b1;
    endtask

    task automatic set_cmd(input bit st);
        cs_n = 1'b0; nv_n = 1'b0;
        if (st) begin we_n = 1'b0; oe_n = 1'b1; end
        else    begin we_n = 1'b1; oe_n = 1'b0; end
    endtask

    task automatic cmd_hold(input bit st, input int n);
        @(negedge clk); set_cmd(st);
        repeat (n) @(negedge clk);
        idle();
    endtask

    task automatic busy_run(output int n);
        n = 0;
        while (busy === 1'b1 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (busy !== 1'b0) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic write_word(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); din = DW'(d);
        cs_n = 1'b0; we_n = 1'b0; nv_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); idle();
        ram_m[a] = DW'(d);
    endtask

    task automatic read_chk(input int a, input string tag);
        @(negedge clk);
        addr = AW'(a);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; nv_n = 1'b1;
        #1;
        chk(dout_en === 1'b1, tag, int'(dout_en), 1);
        chk(dout === ram_m[a], tag, int'(dout), int'(ram_m[a]));
        idle();
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < DEPTH; i++) read_chk(i, tag);
    endtask

    // reset state and power-up recall (R7, R8)
    task automatic t_reset_powerup();
        int n;
        for (int i = 0; i < DEPTH; i++) begin ram_m[i] = '0; nv_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(busy === 1'b0, "reset busy", int'(busy), 0);
        chk(dout_en === 1'b0, "reset dout_en", int'(dout_en), 0);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; nv_n = 1'b1;
        #1;
        chk(dout_en === 1'b0, "R8 read while unpowered", int'(dout_en), 0);
        idle();
        @(negedge clk); supply_ok = 1'b1;
        @(negedge clk);
        busy_run(n);
        chk(n == RC, "R7 power-up recall length", n, RC);
    endtask

    task automatic t_store_refused();
        cmd_hold(1'b1, MP);
        quiet(SC, "R5 store without write");
    endtask

    task automatic t_read_write();
        for (int i = 0; i < DEPTH; i++) write_word(i, 8'h30 + i * 7);
        read_all("R2 write then read");
        for (int k = 0; k < 20; k++) write_word(5, k);
        read_chk(5, "R2 repeated writes");
        @(negedge clk); addr = 3'd1;
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; nv_n = 1'b1; #1;
        chk(dout_en === 1'b0, "R1 oe_n high", int'(dout_en), 0);
        cs_n = 1'b1; oe_n = 1'b0; #1;
        chk(dout_en === 1'b0, "R1 cs_n high", int'(dout_en), 0);
        cs_n = 1'b0; nv_n = 1'b0; #1;
        chk(dout_en === 1'b0, "R1 nv_n low", int'(dout_en), 0);
        idle();
    endtask

    task automatic t_glitch();
        cmd_hold(1'b1, MP - 1);
        quiet(8, "R6 short store strobe");
        cmd_hold(1'b0, MP - 1);
        quiet(8, "R6 short recall strobe");
        read_all("R6 RAM unchanged");
    endtask

    task automatic t_store();
        int n;
        cmd_hold(1'b1, MP);
        chk(busy === 1'b1, "R4 store start", int'(busy), 1);
        busy_run(n);
        chk(n == SC, "R4 store length", n, SC);
        nv_m = ram_m;
        cmd_hold(1'b1, MP);
        quiet(SC, "R5 flag cleared by store");
    endtask

    task automatic t_recall();
        int n;
        for (int i = 0; i < DEPTH; i++) write_word(i, 8'hC0 + i);
        cmd_hold(1'b0, MP);
        chk(busy === 1'b1, "R3 recall start", int'(busy), 1);
        busy_run(n);
        chk(n == RC, "R3 recall length", n, RC);
        ram_m = nv_m;
        read_all("R3 RAM equals shadow");
    endtask

    task automatic t_busy_ignore();
        int guard = 0;
        write_word(2, 8'h5C);
        cmd_hold(1'b1, MP);
        @(negedge clk);
        addr = 3'd2; din = 8'hEE;
        cs_n = 1'b0; we_n = 1'b0; nv_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b0; #1;
        chk(dout_en === 1'b0, "R9 no read while busy", int'(dout_en), 0);
        set_cmd(1'b0);
        while (busy === 1'b1 && guard < 1000) begin guard++; @(negedge clk); end
        quiet(8, "R9 command held through busy");
        idle();
        nv_m = ram_m;
        read_chk(2, "R9 write during busy ignored");
    endtask

    task automatic t_single();
        int cnt = 0;
        @(negedge clk); set_cmd(1'b0);
        repeat (MP + RC + 6) begin
            @(negedge clk);
            if (busy === 1'b1) cnt++;
        end
        idle();
        chk(cnt == RC, "R10 one transfer per assertion", cnt, RC);
        ram_m = nv_m;
    endtask

    task automatic t_supply();
        int cnt = 0;
        write_word(0, 8'h99);
        cmd_hold(1'b1, MP);
        repeat (3) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R8 abort on supply loss", int'(busy), 0);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; nv_n = 1'b1; #1;
        chk(dout_en === 1'b0, "R8 no read while unpowered", int'(dout_en), 0);
        idle();
        cmd_hold(1'b0, MP + 2);
        quiet(4, "R8 no transfer while unpowered");
        // collision: store held across the supply rise
        @(negedge clk); set_cmd(1'b1);
        @(negedge clk); supply_ok = 1'b1;
        repeat (RC + MP + 8) begin
            @(negedge clk);
            if (busy === 1'b1) cnt++;
        end
        idle();
        chk(cnt == RC, "R7 rise beats held store", cnt, RC);
        ram_m = nv_m;
        read_all("R8 aborted store left shadow");
        cmd_hold(1'b1, MP);
        quiet(SC, "R7 written flag cleared at power-up");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset_powerup();
        t_store_refused();
        t_read_write();
        t_glitch();
        t_store();
        t_recall();
        t_busy_ignore();
        t_single();
        t_supply();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule